// File: doc/BRIEF.md
# Interrupt Pin Request and Delivery Arbiter

This block sits between a bank of interrupt input lines and the message fabric that carries interrupts to the processors. A routing table held elsewhere supplies one entry per pin. From that entry the block takes the polarity, the trigger mode, the mask and the fields of the outgoing message. Each cycle the block samples every pin and corrects it for polarity. It keeps a pending-request bit per pin. It decides which pins need a delivery message and sends those messages one at a time, lowest pin first, over a valid/ready handshake.

Edge-triggered pins raise one request for each new assertion. Level-triggered pins are held back by a per-pin in-service flag, which is set when a message leaves for that pin. The flag is released either by an end-of-interrupt message that carries the pin's vector or by a rewrite of the pin's table entry. If the line is still asserted at that point, the pin is delivered again at once. A per-pin pulse output marks each assertion that was absorbed into a request already outstanding.

Top module: `irq_pin_arbiter`

## Requirements
- R1: After reset `dlv_valid` is 0, every `coal_pulse` bit is 0, and every pending and in-service flag is clear.
- R2: The effective request level of pin i is `pin_lvl[i]` XOR the entry's polarity bit (bit 12; 1 = active low). A pin whose effective level is low has its pending bit cleared and raises no level request.
- R3: An unmasked edge-triggered entry (bit 13 = 0) raises exactly one request per 0-to-1 change of the effective level, however long the level stays high. On an idle output, `dlv_valid` rises two clock edges after the pin changes.
- R4: A new edge on an edge-triggered pin whose earlier request has not yet been loaded into the output register is merged with that request, and `coal_pulse[i]` is high for one cycle.
- R5: An unmasked level-triggered entry (bit 13 = 1) whose pending bit is set requests delivery only while its in-service flag is clear. Loading its message sets the flag. A new assertion while the flag is set pulses `coal_pulse[i]`.
- R6: An entry with its mask bit (bit 14) set never delivers and never pulses `coal_pulse`. An edge request that is still waiting is dropped when the entry is masked.
- R7: An end-of-interrupt with `eoi_level` = 1 clears the in-service flag of every entry whose vector (bits 7:0) equals `eoi_vec`. A level pin still asserted is then delivered again. An end-of-interrupt with another vector, or with `eoi_level` = 0, changes nothing.
- R8: A pulse on `ent_wr[i]` clears the in-service flag of entry i. If the entry is then level-triggered, unmasked and its pin is asserted, it is delivered again.
- R9: A message carries the entry's vector (bits 7:0), delivery kind (bits 10:8), destination mode (bit 11), trigger mode (bit 13) and destination (bits 22:15), together with the pin number.
- R10: When several pins request in the same cycle, the lowest-numbered one is loaded first. While `dlv_valid` is high and `dlv_ready` is low, the message holds and no other request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NPINS | Raw interrupt line levels |
| ent_tbl | input | NPINS*23 | Routing entries, entry i in bits [23*i +: 23] |
| ent_wr | input | NPINS | One-cycle pulse: entry i was rewritten |
| eoi_valid | input | 1 | End-of-interrupt message present |
| eoi_vec | input | 8 | Vector of the end-of-interrupt |
| eoi_level | input | 1 | 1 = level-mode end-of-interrupt |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Receiver accepts the message |
| dlv_pin | output | 3 | Pin that produced the message |
| dlv_vec | output | 8 | Vector |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_level | output | 1 | Trigger mode, 1 = level |
| dlv_kind | output | 3 | Delivery kind |
| coal_pulse | output | NPINS | One-cycle marker of a merged assertion |

## Verification
Edge pins are driven with one long assertion, to separate per-edge delivery from per-cycle delivery, and with repeated pulses while the output is stalled, to show merging. Active-low pins are driven from the inactive-high state, which separates a polarity-correct design from one that fires on the raw level. A level pin is held, pulsed and then released by end-of-interrupt messages with the wrong vector, with the wrong mode and with the right values, and finally by an entry rewrite. Only the right release may deliver again. Two simultaneous edges under a stalled receiver show the priority order and that the message holds. A reference model compares every output on every cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int KIND_W = 3;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              lvl;
        logic              pol;
        logic              dstm;
        logic [KIND_W-1:0] kind;
        logic [VEC_W-1:0]  vec;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    typedef struct packed {
        logic irr;
        logic insvc;
        logic epend;
        logic coal;
    } slot_st_t;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  onehot_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        onehot_o = '0;
        idx_o    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
                idx_o       = IW'(i);
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic pol_i,
    input  logic trig_lvl_i,
    input  logic mask_i,
    input  logic wr_i,
    input  logic eoi_hit_i,
    input  logic grant_i,
    output logic req_o,
    output logic coal_o
);
    slot_st_t st_d, st_q;
    logic eff, rise;

    always_comb begin
        eff  = lvl_i ^ pol_i;
        rise = eff & ~st_q.irr;
        st_d = st_q;
        st_d.irr = eff;

        st_d.epend = st_q.epend & ~grant_i;
        if (rise)
            st_d.epend = 1'b1;
        if (mask_i || trig_lvl_i)
            st_d.epend = 1'b0;

        if (wr_i || eoi_hit_i)
            st_d.insvc = 1'b0;
        if (grant_i && trig_lvl_i)
            st_d.insvc = 1'b1;

        st_d.coal = rise & ~mask_i &
                    ((~trig_lvl_i & st_q.epend & ~grant_i) |
                     (trig_lvl_i & st_q.insvc & ~eoi_hit_i & ~wr_i));

        req_o = ~mask_i & ((~trig_lvl_i & st_q.epend) |
                           (trig_lvl_i & st_q.irr & ~st_q.insvc));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign coal_o = st_q.coal;

    // R5
    insvc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.insvc) |-> $past(grant_i));

    // R4
    coal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.coal |-> $past(st_q.epend | st_q.insvc));

    // R6
    masked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> !mask_i);
endmodule

// File: rtl/irq_pin_arbiter.sv
module irq_pin_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       pin_lvl,
    input  logic [NPINS*ENT_W-1:0] ent_tbl,
    input  logic [NPINS-1:0]       ent_wr,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vec,
    input  logic                   eoi_level,
    output logic                   dlv_valid,
    input  logic                   dlv_ready,
    output logic [PIN_W-1:0]       dlv_pin,
    output logic [VEC_W-1:0]       dlv_vec,
    output logic [DEST_W-1:0]      dlv_dest,
    output logic                   dlv_dest_mode,
    output logic                   dlv_level,
    output logic [KIND_W-1:0]      dlv_kind,
    output logic [NPINS-1:0]       coal_pulse
);
    typedef struct packed {
        logic              val;
        logic [PIN_W-1:0]  pin;
        logic [VEC_W-1:0]  vec;
        logic [DEST_W-1:0] dest;
        logic              dstm;
        logic              lvl;
        logic [KIND_W-1:0] kind;
    } msg_t;

    ent_t             ents [NPINS];
    logic [NPINS-1:0] req, pick_oh, grant;
    logic [PIN_W-1:0] pick_idx;
    logic             pick_any, load;
    msg_t             out_d, out_q;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic hit;
        assign ents[g] = ent_t'(ent_tbl[g*ENT_W +: ENT_W]);
        assign hit = eoi_valid & eoi_level & (ents[g].vec == eoi_vec);

        irq_pin_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (pin_lvl[g]),
            .pol_i      (ents[g].pol),
            .trig_lvl_i (ents[g].lvl),
            .mask_i     (ents[g].mask),
            .wr_i       (ent_wr[g]),
            .eoi_hit_i  (hit),
            .grant_i    (grant[g]),
            .req_o      (req[g]),
            .coal_o     (coal_pulse[g])
        );
    end

    irq_lowest_pick #(.N(NPINS), .IW(PIN_W)) u_pick (
        .req_i    (req),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx),
        .any_o    (pick_any)
    );

    always_comb begin
        load  = pick_any & (~out_q.val | dlv_ready);
        grant = load ? pick_oh : '0;
        out_d = out_q;
        if (load) begin
            out_d.val  = 1'b1;
            out_d.pin  = pick_idx;
            out_d.vec  = ents[pick_idx].vec;
            out_d.dest = ents[pick_idx].dest;
            out_d.dstm = ents[pick_idx].dstm;
            out_d.lvl  = ents[pick_idx].lvl;
            out_d.kind = ents[pick_idx].kind;
        end else if (dlv_ready) begin
            out_d.val = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign dlv_valid     = out_q.val;
    assign dlv_pin       = out_q.pin;
    assign dlv_vec       = out_q.vec;
    assign dlv_dest      = out_q.dest;
    assign dlv_dest_mode = out_q.dstm;
    assign dlv_level     = out_q.lvl;
    assign dlv_kind      = out_q.kind;

    // R10
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10
    hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(out_q)));

    // R3
    new_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_valid) |-> $past(|req));
endmodule

// File: tb/sim_irq_pin_arbiter.sv
module sim_irq_pin_arbiter;
    import irq_arb_pkg::*;

    localparam int NP = 8;
    localparam int PW = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      pins = '0;
    logic [NP*ENT_W-1:0] flat;
    logic [NP-1:0]      wr = '0;
    logic               eoi_v = 1'b0;
    logic [VEC_W-1:0]   eoi_vec = '0;
    logic               eoi_lvl = 1'b0;
    logic               rdy = 1'b0;
    logic               dlv_valid, dlv_dest_mode, dlv_level;
    logic [PW-1:0]      dlv_pin;
    logic [VEC_W-1:0]   dlv_vec;
    logic [DEST_W-1:0]  dlv_dest;
    logic [KIND_W-1:0]  dlv_kind;
    logic [NP-1:0]      coal;

    ent_t tbl [NP];
    always_comb
        for (int i = 0; i < NP; i++) flat[i*ENT_W +: ENT_W] = tbl[i];

    irq_pin_arbiter #(.NPINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .ent_tbl(flat), .ent_wr(wr),
        .eoi_valid(eoi_v), .eoi_vec(eoi_vec), .eoi_level(eoi_lvl),
        .dlv_valid(dlv_valid), .dlv_ready(rdy), .dlv_pin(dlv_pin),
        .dlv_vec(dlv_vec), .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode),
        .dlv_level(dlv_level), .dlv_kind(dlv_kind), .coal_pulse(coal)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference state
    bit   m_irr [NP], m_rem [NP], m_ep [NP];
    bit   m_val;
    int   m_pin;
    ent_t m_msg;
    bit [NP-1:0] m_coal;
    int   dcnt [NP];
    int   ccnt [NP];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        int   first = -1;
        bit   can;
        bit   n_irr [NP], n_rem [NP], n_ep [NP];
        bit [NP-1:0] n_coal;
        can = !m_val || rdy;
        if (m_val && rdy) dcnt[m_pin]++;
        for (int i = 0; i < NP; i++) begin
            if (first < 0 && !tbl[i].mask &&
                ((!tbl[i].lvl && m_ep[i]) || (tbl[i].lvl && m_irr[i] && !m_rem[i])))
                first = i;
        end
        for (int i = 0; i < NP; i++) begin
            bit eff, rise, hit, g;
            eff  = pins[i] ^ tbl[i].pol;
            rise = eff && !m_irr[i];
            hit  = eoi_v && eoi_lvl && (tbl[i].vec == eoi_vec);
            g    = can && (first == i);
            n_coal[i] = rise && !tbl[i].mask &&
                ((!tbl[i].lvl && m_ep[i] && !g) ||
                 (tbl[i].lvl && m_rem[i] && !hit && !wr[i]));
            n_ep[i] = m_ep[i] && !g;
            if (rise) n_ep[i] = 1'b1;
            if (tbl[i].mask || tbl[i].lvl) n_ep[i] = 1'b0;
            n_rem[i] = m_rem[i];
            if (hit || wr[i]) n_rem[i] = 1'b0;
            if (g && tbl[i].lvl) n_rem[i] = 1'b1;
            n_irr[i] = eff;
        end
        if (can && first >= 0) begin
            m_val = 1'b1;
            m_pin = first;
            m_msg = tbl[first];
        end else if (rdy) begin
            m_val = 1'b0;
        end
        m_irr = n_irr; m_rem = n_rem; m_ep = n_ep; m_coal = n_coal;
        @(posedge clk);
        #1;
        for (int i = 0; i < NP; i++) if (coal[i]) ccnt[i]++;
        chk(dlv_valid == m_val, tag, "dlv_valid", dlv_valid, m_val);
        chk(coal == m_coal, tag, "coal_pulse", coal, m_coal);
        if (m_val && dlv_valid) begin
            chk(dlv_pin == PW'(m_pin), tag, "dlv_pin", dlv_pin, m_pin);
            // R9 message fields
            chk(dlv_vec == m_msg.vec && dlv_dest == m_msg.dest &&
                dlv_dest_mode == m_msg.dstm && dlv_level == m_msg.lvl &&
                dlv_kind == m_msg.kind, "R9", "fields",
                {dlv_dest, dlv_vec}, {m_msg.dest, m_msg.vec});
        end
    endtask

    task automatic steps(int n, string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    function automatic ent_t mk(bit [7:0] vec, bit lvl, bit pol, bit mask, bit [7:0] dest);
        ent_t e;
        e.vec = vec; e.kind = 3'(vec[2:0]); e.dstm = vec[0];
        e.pol = pol; e.lvl = lvl; e.mask = mask; e.dest = dest;
        return e;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            tbl[i] = mk(8'(8'h10 + i), 1'b0, 1'b0, 1'b1, 8'(i * 3));
            m_irr[i] = 0; m_rem[i] = 0; m_ep[i] = 0; dcnt[i] = 0; ccnt[i] = 0;
        end
        m_val = 0; m_pin = 0; m_coal = '0; m_msg = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk(dlv_valid == 1'b0, "R1", "dlv_valid after reset", dlv_valid, 0);
        chk(coal == '0, "R1", "coal_pulse after reset", coal, 0);

        // R3: long edge assertion gives one message
        rdy = 1'b1;
        tbl[2] = mk(8'h22, 1'b0, 1'b0, 1'b0, 8'hA2);
        step("R3");
        pins[2] = 1'b1;
        step("R3");
        chk(dlv_valid == 1'b0, "R3", "valid after one edge", dlv_valid, 0);
        step("R3");
        chk(dlv_valid == 1'b1 && dlv_pin == 3'd2, "R3", "valid after two edges", dlv_pin, 2);
        steps(6, "R3");
        chk(dcnt[2] == 1, "R3", "edge deliveries", dcnt[2], 1);
        pins[2] = 1'b0;
        steps(2, "R3");

        // R2: active-low pin, inactive-high level must not fire
        pins[3] = 1'b1;
        step("R2");
        tbl[3] = mk(8'h33, 1'b0, 1'b1, 1'b0, 8'hB3);
        steps(4, "R2");
        chk(dcnt[3] == 0, "R2", "inactive high, active low", dcnt[3], 0);
        pins[3] = 1'b0;
        steps(5, "R2");
        chk(dcnt[3] == 1, "R2", "low level delivers", dcnt[3], 1);

        // R4: merged edges while the output is stalled
        rdy = 1'b0;
        tbl[4] = mk(8'h44, 1'b0, 1'b0, 1'b0, 8'hC4);
        pins[4] = 1'b1; step("R4");
        step("R4");
        pins[4] = 1'b0; step("R4");
        pins[4] = 1'b1; step("R4");
        pins[4] = 1'b0; step("R4");
        pins[4] = 1'b1; step("R4");
        chk(ccnt[4] == 1, "R4", "coalesced pulses", ccnt[4], 1);
        rdy = 1'b1;
        steps(5, "R4");
        chk(dcnt[4] == 2, "R4", "deliveries after merge", dcnt[4], 2);
        pins[4] = 1'b0; step("R4");

        // R6: masked pin
        tbl[6] = mk(8'h66, 1'b0, 1'b0, 1'b1, 8'hD6);
        pins[6] = 1'b1; steps(5, "R6");
        chk(dcnt[6] == 0 && ccnt[6] == 0, "R6", "masked activity", dcnt[6] + ccnt[6], 0);
        pins[6] = 1'b0; step("R6");

        // R5: level pin held by the in-service flag
        tbl[5] = mk(8'h55, 1'b1, 1'b0, 1'b0, 8'hE5);
        pins[5] = 1'b1; steps(8, "R5");
        chk(dcnt[5] == 1, "R5", "level deliveries while in service", dcnt[5], 1);
        pins[5] = 1'b0; step("R5");
        pins[5] = 1'b1; steps(3, "R5");
        chk(ccnt[5] == 1, "R5", "level coalesced", ccnt[5], 1);

        // R7: end-of-interrupt filtering
        eoi_v = 1'b1; eoi_vec = 8'h56; eoi_lvl = 1'b1; step("R7");
        eoi_v = 1'b0; steps(4, "R7");
        chk(dcnt[5] == 1, "R7", "wrong vector", dcnt[5], 1);
        eoi_v = 1'b1; eoi_vec = 8'h55; eoi_lvl = 1'b0; step("R7");
        eoi_v = 1'b0; steps(4, "R7");
        chk(dcnt[5] == 1, "R7", "edge-mode eoi", dcnt[5], 1);
        eoi_v = 1'b1; eoi_lvl = 1'b1; step("R7");
        eoi_v = 1'b0; steps(4, "R7");
        chk(dcnt[5] == 2, "R7", "matching eoi redelivers", dcnt[5], 2);

        // R8: rewrite releases the flag
        wr[5] = 1'b1; step("R8");
        wr[5] = 1'b0; steps(4, "R8");
        chk(dcnt[5] == 3, "R8", "rewrite redelivers", dcnt[5], 3);
        pins[5] = 1'b0; step("R7");
        eoi_v = 1'b1; step("R7");
        eoi_v = 1'b0; steps(4, "R7");
        chk(dcnt[5] == 3, "R7", "released line not redelivered", dcnt[5], 3);

        // R10: priority and hold
        rdy = 1'b0;
        tbl[0] = mk(8'h70, 1'b0, 1'b0, 1'b0, 8'h01);
        tbl[1] = mk(8'h71, 1'b0, 1'b0, 1'b0, 8'h02);
        pins[1:0] = 2'b11;
        steps(2, "R10");
        chk(dlv_valid && dlv_pin == 3'd0, "R10", "lowest pin first", dlv_pin, 0);
        steps(3, "R10");
        chk(dlv_valid && dlv_pin == 3'd0 && dlv_vec == 8'h70, "R10", "held message", dlv_vec, 8'h70);
        rdy = 1'b1;
        step("R10");
        chk(dlv_valid && dlv_pin == 3'd1, "R10", "next pin after accept", dlv_pin, 1);
        steps(4, "R10");
        chk(dcnt[0] == 1 && dcnt[1] == 1, "R10", "both delivered", dcnt[0] + dcnt[1], 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule